// File: doc/BRIEF.md
# ADC Conversion Clock Generator

This block produces the conversion clock that paces a successive-approximation ADC controller. It also frames one conversion as a fixed number of those clock periods. The conversion clock comes from one of two sources. The first is a programmable divider on the fast system clock, which runs at twice the instruction rate. The second is a free-running internal RC clock that is asynchronous to the system clock. In either case the block emits a one-cycle tick for every conversion clock period.

A start strobe begins a conversion. At that moment the divider setting and the source choice are captured. The busy flag stays high until the fourteenth tick. A one-cycle done pulse then follows, and busy is already low in that cycle. With a divider setting N, one tick occurs every N+1 system clock cycles. The resulting period is (N+1)/2 instruction cycles. Integration must choose N so that this period is not shorter than the analog minimum, which is about 667 ns at 5 V.

The controller is a three-state machine:
- IDLE waits for start. IDLE→CONV is taken on start.
- CONV counts ticks. CONV→DONE is taken on the tick that completes the conversion.
- DONE lasts one cycle and drives the done pulse. DONE→IDLE is taken when there is no start. DONE→CONV is taken when start is present.

Top module: `adc_tad_gen`

## Requirements
- R1: During and right after reset, busy, done and tad_tick are 0.
- R2: With rc_sel=0 captured, tad_tick pulses in busy cycles N, 2N+1, … counted from 0. Here N is the captured div_set, so ticks are exactly N+1 system clock cycles apart.
- R3: A captured div_set of 0 gives a tick on every cycle of the conversion, with no skipped ticks. Busy then lasts 14 cycles.
- R4: A conversion contains exactly 14 ticks. Busy rises on the cycle after start is sampled and stays high for 14·(N+1) cycles in divider mode.
- R5: done is high for exactly one cycle, immediately after the last busy cycle, and busy is 0 in that cycle.
- R6: A start strobe while busy is high is ignored. The running conversion keeps its length and tick count.
- R7: Changes to div_set or rc_sel while busy have no effect until the next start.
- R8: With rc_sel=1 captured, one tick is produced per rising edge of rc_clk after a two-flop synchronizer, and div_set is ignored. With rc_clk static, no ticks occur and busy stays high.
- R9: tad_tick is 0 whenever busy is 0.
- R10: Asserting reset in the middle of a conversion clears busy and stops ticks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the instruction rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_clk | input | 1 | Free-running internal RC clock, asynchronous |
| div_set | input | 6 | Divider setting N; period = N+1 system cycles |
| rc_sel | input | 1 | 1 selects the RC clock as tick source |
| start | input | 1 | Start-conversion strobe |
| tad_tick | output | 1 | One-cycle pulse per conversion clock period |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-cycle pulse after the 14th tick |

## Verification
The bench builds the block with its defaults: a 6-bit divider, 14 periods per conversion and two synchronizer stages. Under these defaults the full setting range is reachable, up to the largest setting of 63, which gives an 896-cycle conversion. The stimulus table covers settings 0, 1, 2, 5, 13 and 63, and checks the exact tick spacing and conversion length for each. Directed runs exercise the RC source with a slow clock and with a stopped clock, an ignored restart, a change of configuration while busy, and a reset during a conversion.

// File: rtl/adc_tad_pkg.sv
package adc_tad_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_DONE = 2'd2
    } conv_state_e;

endpackage

// File: rtl/adc_rc_sync.sv
module adc_rc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rc_in,
    output logic rise
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh;

    generate
        for (genvar g = 0; g < LEN; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[g] <= 1'b0;
                    else        sh[g] <= rc_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sh[g] <= 1'b0;
                    else        sh[g] <= sh[g-1];
                end
            end
        end
    endgenerate

    assign rise = sh[STAGES-1] & ~sh[STAGES];

    // R8: a detected edge is a single-cycle event
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/adc_tad_div.sv
module adc_tad_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] limit,
    output logic             hit
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt == limit) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == limit);

    // R2: after each tick the count restarts from zero
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0));

    // R2: count never passes the limit while running
    assert_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt <= limit));

endmodule

// File: rtl/adc_conv_fsm.sv
module adc_conv_fsm
    import adc_tad_pkg::*;
#(
    parameter int CONV_TADS = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic busy,
    output logic done,
    output logic capture
);
    localparam int PCW = $clog2(CONV_TADS);
    localparam logic [PCW-1:0] LAST = PCW'(CONV_TADS - 1);

    conv_state_e      state, state_nx;
    logic [PCW-1:0]   pcnt;
    logic             last_tick;

    assign last_tick = tick && (pcnt == LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)     state_nx = ST_CONV;
            ST_CONV: if (last_tick) state_nx = ST_DONE;
            ST_DONE: state_nx = start ? ST_CONV : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         pcnt <= '0;
        else if (capture)                   pcnt <= '0;
        else if (state == ST_CONV && tick)  pcnt <= last_tick ? '0 : pcnt + 1'b1;
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE: capture = start;
            ST_CONV: busy    = 1'b1;
            ST_DONE: begin
                done    = 1'b1;
                capture = start;
            end
            default: ;
        endcase
    end

    // R4: period counter stays inside the conversion length
    assert_pcnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= LAST);

    // R5: done comes with busy low and lasts one cycle
    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a conversion begins only from a sampled start
    assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

endmodule

// File: rtl/adc_tad_gen.sv
module adc_tad_gen #(
    parameter int DIV_W       = 6,
    parameter int CONV_TADS   = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rc_clk,
    input  logic [DIV_W-1:0] div_set,
    input  logic             rc_sel,
    input  logic             start,
    output logic             tad_tick,
    output logic             busy,
    output logic             done
);
    logic [DIV_W-1:0] cfg_set;
    logic             cfg_rc;
    logic             capture;
    logic             rc_rise;
    logic             div_hit;
    logic             tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_set <= '0;
            cfg_rc  <= 1'b0;
        end else if (capture) begin
            cfg_set <= div_set;
            cfg_rc  <= rc_sel;
        end
    end

    adc_rc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rc_in (rc_clk),
        .rise  (rc_rise)
    );

    adc_tad_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy && !cfg_rc),
        .limit (cfg_set),
        .hit   (div_hit)
    );

    assign tick = busy && (cfg_rc ? rc_rise : div_hit);

    adc_conv_fsm #(.CONV_TADS(CONV_TADS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tick    (tick),
        .busy    (busy),
        .done    (done),
        .capture (capture)
    );

    assign tad_tick = tick;

    // R7: captured configuration holds for the whole conversion
    assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_set) && $stable(cfg_rc)));

    // R9: no tick outside a conversion
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tad_tick);

endmodule

// File: tb/adc_tad_gen_test.sv
module adc_tad_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rc_clk = 1'b0;
    logic [5:0] div_set = '0;
    logic       rc_sel = 1'b0;
    logic       start = 1'b0;
    logic       tad_tick, busy, done;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    adc_tad_gen uut (
        .clk(clk), .rst_n(rst_n), .rc_clk(rc_clk), .div_set(div_set),
        .rc_sel(rc_sel), .start(start), .tad_tick(tad_tick),
        .busy(busy), .done(done)
    );

    localparam int NV = 6;
    localparam int VSET [NV] = '{0, 1, 2, 5, 13, 63};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse start, then measure busy length, tick count, first tick index, spacing
    task automatic run_div(input int n, input int inject_at,
                           output int blen, output int nt,
                           output int first, output bit spacing_ok,
                           output bit done_ok);
        int last;
        @(negedge clk);
        div_set = 6'(n); rc_sel = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        blen = 0; nt = 0; first = -1; last = -1; spacing_ok = 1'b1;
        while (busy && blen < 2000) begin
            if (tad_tick) begin
                if (first < 0) first = blen;
                if (last >= 0 && blen - last != n + 1) spacing_ok = 1'b0;
                last = blen;
                nt++;
            end
            if (blen == inject_at) begin
                start = 1'b1; div_set = 6'd0; rc_sel = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            blen++;
        end
        start = 1'b0;
        done_ok = done && !busy;
        @(negedge clk);
        done_ok = done_ok && !done;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int blen, nt, first, ticks, dn;
        bit sp, dok, bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!busy && !done && !tad_tick, "R1 reset", {busy, done, tad_tick}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !tad_tick, "R1 after reset", {busy, done, tad_tick}, 0);

        // R9: idle with setting 0 gives no ticks
        div_set = 6'd0;
        bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tad_tick || busy) bad = 1'b1;
        end
        chk(!bad, "R9 idle quiet", bad, 0);

        // Table walk: R2, R3, R4, R5
        for (int v = 0; v < NV; v++) begin
            run_div(VSET[v], -1, blen, nt, first, sp, dok);
            chk(blen == 14 * (VSET[v] + 1), "R4 busy length", blen, 14 * (VSET[v] + 1));
            chk(nt == 14, "R4 tick count", nt, 14);
            chk(first == VSET[v], "R2 first tick", first, VSET[v]);
            chk(sp, (VSET[v] == 0) ? "R3 every cycle" : "R2 spacing", sp, 1);
            chk(dok, "R5 done pulse", dok, 1);
        end

        // R6 + R7: restart and config change mid-conversion ignored
        run_div(3, 10, blen, nt, first, sp, dok);
        chk(blen == 56, "R6 R7 busy length", blen, 56);
        chk(nt == 14 && sp, "R7 ticks unchanged", nt, 14);
        chk(dok, "R6 done pulse", dok, 1);
        // next conversion uses new setting 0 from div_set
        run_div(0, -1, blen, nt, first, sp, dok);
        chk(blen == 14, "R7 new setting applies", blen, 14);

        // R8: RC source, static clock first
        @(negedge clk);
        div_set = 6'd63; rc_sel = 1'b1; start = 1'b1; rc_clk = 1'b0;
        @(negedge clk);
        start = 1'b0;
        ticks = 0;
        for (int i = 0; i < 100; i++) begin
            if (tad_tick) ticks++;
            @(negedge clk);
        end
        chk(ticks == 0 && busy, "R8 static rc no ticks", ticks, 0);
        // R8: 14 rising edges of a 6-cycle rc clock complete the conversion
        ticks = 0; dn = 0; bad = 1'b0;
        for (int c = 0; c < 120; c++) begin
            if (tad_tick) ticks++;
            if (done) begin dn++; if (busy) bad = 1'b1; end
            rc_clk = ((c / 3) % 2) == 1;
            @(negedge clk);
        end
        chk(ticks == 14, "R8 rc ticks", ticks, 14);
        chk(dn == 1 && !bad && !busy, "R8 rc done", dn, 1);
        rc_clk = 1'b0; rc_sel = 1'b0;

        // R10: reset during conversion
        run_div(0, -1, blen, nt, first, sp, dok);
        @(negedge clk);
        div_set = 6'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        chk(busy, "R10 busy before reset", busy, 1);
        rst_n = 1'b0;
        #1;
        chk(!busy && !tad_tick && !done, "R10 reset clears", {busy, tad_tick, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!busy && !tad_tick, "R10 stays idle", {busy, tad_tick}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule